// File: doc/BRIEF.md
# Video Raster Sequencer with Pixel Repacking

This block drives a raster display from a pixel clock. Horizontal and vertical counters produce the sync pulses and the blanking signal for one of three fixed display modes, or for a custom mode whose porch, sync and active lengths are given as parameters. While the beam is in the visible window, the block takes 32-bit memory words from a first-word-fall-through pixel FIFO. It splits each word into pixels and sends them to a video DAC as three 8-bit colour channels.

Two pixel formats are built in. The first uses 16 bits per pixel, with two 5-6-5 pixels in each word. The second uses 24 bits per pixel, with four pixels packed tightly into three words. If the FIFO runs dry when a word is needed, the block raises a sticky underflow flag and shows black until the next frame begins. At that point the unpacking restarts at a word boundary.

Top module: `vga_sequencer`

## Requirements
- R1: Parameter `RES` selects the mode: 0 gives 640x480 (line 800 clocks: 640 visible, 16 front porch, 96 sync, 48 back porch; frame 525 lines: 480, 10, 2, 33; both syncs active low), 1 gives 800x600 (1056 clocks: 800/40/128/88; 628 lines: 600/1/4/23; both syncs active high), 2 gives 1024x768 (1344 clocks: 1024/24/136/160; 806 lines: 768/3/6/29; both syncs active low), and 3 takes the lengths and polarities from the `USR_*` parameters.
- R2: `hsync` sits at its active level for exactly the sync length of each line. It starts front-porch clocks after `blank` rises at the end of the visible part of the line.
- R3: `vsync` sits at its active level for exactly the vertical sync length in lines, as one unbroken run of clocks.
- R4: `blank` is low for exactly (visible pixels x visible lines) clocks per frame. While `blank` is high, `red`, `green` and `blue` are all zero.
- R5: `fifo_pop` is asserted only when `fifo_empty` is low and the current pixel slot is visible. In the clock after a pop, `blank` is low.
- R6: In a frame with no underflow, the block pops exactly half of the visible pixel count in words when `BPP`=16, and exactly three quarters of it when `BPP`=24.
- R7: With `BPP`=16, pixel 2n takes bits [15:0] of word n and pixel 2n+1 takes bits [31:16]. Each 16-bit pixel holds red in [15:11], green in [10:5] and blue in [4:0]. Each channel is widened to 8 bits by appending its own top bits: red and blue append their top 3 bits, and green appends its top 2 bits.
- R8: With `BPP`=24, pixels are 24-bit values {red[23:16], green[15:8], blue[7:0]}. They are laid out byte-contiguously in little-endian order, so pixel 0 is word0[23:0], pixel 1 is {word1[15:0], word0[31:24]}, pixel 2 is {word2[7:0], word1[31:16]} and pixel 3 is word2[31:8]. The pattern repeats every three words.
- R9: If a word is needed while `fifo_empty` is high, `underflow` rises on the clock that would have shown that pixel. It stays high, with black output and no pops, until the first visible pixel of the next frame, where it reads low again.
- R10: At the first pixel of every frame, the unpacking restarts at pixel 0 of a fresh word group, even if an underflow stopped the previous frame part-way through a group.
- R11: All display outputs are registered. The colour of a pixel appears one clock after the cycle in which its word (or its first word) was popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_data | input | 32 | Head word of the pixel FIFO (valid while not empty) |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Consume the head word this clock |
| hsync | output | 1 | Horizontal sync, polarity per mode |
| vsync | output | 1 | Vertical sync, polarity per mode |
| blank | output | 1 | High outside the visible window |
| red | output | 8 | Red channel to the DAC |
| green | output | 8 | Green channel to the DAC |
| blue | output | 8 | Blue channel to the DAC |
| underflow | output | 1 | Sticky FIFO starvation flag, cleared at frame start |

## Verification
Both pixel formats receive a stream of word values built from a multiplicative hash. Every byte position therefore carries different bits, so a swapped half, a misplaced byte in the three-word group or a wrong replication bit changes the observed colour. The FIFO is starved on the second pixel of a frame, which lands in the middle of a 24-bit group. This case separates a flag that is sticky from one that clears itself, and a phase reset at frame start from a phase that merely continues. The sync and blanking shapes are measured as run lengths, both on a small custom mode over whole frames and on the 640x480 mode over full lines.

// File: rtl/vga_seq_pkg.sv
package vga_seq_pkg;

    typedef struct packed {
        logic [15:0] h_act;
        logic [15:0] h_fp;
        logic [15:0] h_sync;
        logic [15:0] h_bp;
        logic [15:0] v_act;
        logic [15:0] v_fp;
        logic [15:0] v_sync;
        logic [15:0] v_bp;
        logic        h_pos;
        logic        v_pos;
    } vga_mode_t;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    // Built-in display modes, 60 Hz refresh
    function automatic vga_mode_t mode_preset(input int sel);
        vga_mode_t m;
        case (sel)
            1:       m = '{16'd800,  16'd40, 16'd128, 16'd88,
                           16'd600,  16'd1,  16'd4,   16'd23, 1'b1, 1'b1};
            2:       m = '{16'd1024, 16'd24, 16'd136, 16'd160,
                           16'd768,  16'd3,  16'd6,   16'd29, 1'b0, 1'b0};
            default: m = '{16'd640,  16'd16, 16'd96,  16'd48,
                           16'd480,  16'd10, 16'd2,   16'd33, 1'b0, 1'b0};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vga_raster_timing.sv
module vga_raster_timing #(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter bit H_POS  = 1'b0,
    parameter bit V_POS  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    output logic visible,
    output logic frame_start,
    output logic hs_level,
    output logic vs_level
);
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
    localparam logic [HW-1:0] HS_BEG = HW'(H_ACT + H_FP);
    localparam logic [HW-1:0] HS_END = HW'(H_ACT + H_FP + H_SYNC);
    localparam logic [VW-1:0] VS_BEG = VW'(V_ACT + V_FP);
    localparam logic [VW-1:0] VS_END = VW'(V_ACT + V_FP + V_SYNC);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } cnt_s;

    cnt_s st_q, st_d;
    logic hs_on, vs_on;

    always_comb begin
        st_d = st_q;
        if (st_q.h == H_LAST) begin
            st_d.h = '0;
            st_d.v = (st_q.v == V_LAST) ? '0 : st_q.v + 1'b1;
        end else begin
            st_d.h = st_q.h + 1'b1;
        end
        hs_on       = (st_q.h >= HS_BEG) && (st_q.h < HS_END);
        vs_on       = (st_q.v >= VS_BEG) && (st_q.v < VS_END);
        visible     = (st_q.h < HW'(H_ACT)) && (st_q.v < VW'(V_ACT));
        frame_start = (st_q.h == '0) && (st_q.v == '0);
        hs_level    = H_POS ? hs_on : ~hs_on;
        vs_level    = V_POS ? vs_on : ~vs_on;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: line counter wraps to zero after its last count
    a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.h == H_LAST) |=> (st_q.h == '0));
    // R3: frame counter advances only across a line wrap
    a_r3_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.h != H_LAST) |=> $stable(st_q.v));

endmodule

// File: rtl/vga_unpack16.sv
module vga_unpack16
    import vga_seq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              restart,
    input  logic [WORD_W-1:0] word,
    input  logic              empty,
    output logic              pop,
    output logic              starve,
    output rgb_t              pix
);
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic              odd;
        logic [HALF_W-1:0] hold;
    } u16_s;

    u16_s st_q, st_d;
    logic odd_eff, need;
    logic [15:0] half;

    always_comb begin
        st_d    = st_q;
        odd_eff = restart ? 1'b0 : st_q.odd;
        st_d.odd = odd_eff;
        need    = req & ~odd_eff;
        starve  = need & empty;
        pop     = need & ~empty;
        half    = odd_eff ? st_q.hold[15:0] : word[15:0];
        if (req && !starve) begin
            st_d.odd = ~odd_eff;
            if (!odd_eff) st_d.hold = word[WORD_W-1:HALF_W];
        end
        pix.r = {half[15:11], half[15:13]};
        pix.g = {half[10:5],  half[10:9]};
        pix.b = {half[4:0],   half[4:2]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: one word serves two consecutive pixels
    a_r6_pop_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !pop);

endmodule

// File: rtl/vga_unpack24.sv
module vga_unpack24
    import vga_seq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              restart,
    input  logic [WORD_W-1:0] word,
    input  logic              empty,
    output logic              pop,
    output logic              starve,
    output rgb_t              pix
);
    localparam int PIX_W = 24;

    typedef struct packed {
        logic [1:0]       ph;
        logic [PIX_W-1:0] carry;
    } u24_s;

    u24_s st_q, st_d;
    logic [1:0] ph_eff;
    logic need;
    logic [PIX_W-1:0] px, carry_nx;

    always_comb begin
        st_d   = st_q;
        ph_eff = restart ? 2'd0 : st_q.ph;
        st_d.ph = ph_eff;
        need   = req && (ph_eff != 2'd3);
        starve = need & empty;
        pop    = need & ~empty;
        case (ph_eff)
            2'd0: begin
                px       = word[23:0];
                carry_nx = {16'd0, word[31:24]};
            end
            2'd1: begin
                px       = {word[15:0], st_q.carry[7:0]};
                carry_nx = {8'd0, word[31:16]};
            end
            2'd2: begin
                px       = {word[7:0], st_q.carry[15:0]};
                carry_nx = word[31:8];
            end
            default: begin
                px       = st_q.carry;
                carry_nx = '0;
            end
        endcase
        if (req && !starve) begin
            st_d.ph    = ph_eff + 2'd1;
            st_d.carry = carry_nx;
        end
        pix = px;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the fourth pixel of a group takes no word
    a_r6_group_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == 2'd3 && !restart) |-> !pop);

endmodule

// File: rtl/vga_sequencer.sv
module vga_sequencer
    import vga_seq_pkg::*;
#(
    parameter int RES        = 0,
    parameter int BPP        = 16,
    parameter int WORD_W     = 32,
    parameter int USR_H_ACT  = 640,
    parameter int USR_H_FP   = 16,
    parameter int USR_H_SYNC = 96,
    parameter int USR_H_BP   = 48,
    parameter int USR_V_ACT  = 480,
    parameter int USR_V_FP   = 10,
    parameter int USR_V_SYNC = 2,
    parameter int USR_V_BP   = 33,
    parameter bit USR_H_POS  = 1'b0,
    parameter bit USR_V_POS  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    output logic              hsync,
    output logic              vsync,
    output logic              blank,
    output logic [7:0]        red,
    output logic [7:0]        green,
    output logic [7:0]        blue,
    output logic              underflow
);
    localparam vga_mode_t USR_MODE = '{16'(USR_H_ACT), 16'(USR_H_FP),
                                       16'(USR_H_SYNC), 16'(USR_H_BP),
                                       16'(USR_V_ACT), 16'(USR_V_FP),
                                       16'(USR_V_SYNC), 16'(USR_V_BP),
                                       USR_H_POS, USR_V_POS};
    localparam vga_mode_t MODE = (RES == 3) ? USR_MODE : mode_preset(RES);

    typedef struct packed {
        logic hs;
        logic vs;
        logic blank;
        logic uf;
        rgb_t pix;
    } out_s;

    out_s o_q, o_d;
    logic visible, fstart, hs_lvl, vs_lvl;
    logic uf_eff, req, starve;
    rgb_t pix;

    vga_raster_timing #(
        .H_ACT (int'(MODE.h_act)),  .H_FP  (int'(MODE.h_fp)),
        .H_SYNC(int'(MODE.h_sync)), .H_BP  (int'(MODE.h_bp)),
        .V_ACT (int'(MODE.v_act)),  .V_FP  (int'(MODE.v_fp)),
        .V_SYNC(int'(MODE.v_sync)), .V_BP  (int'(MODE.v_bp)),
        .H_POS (MODE.h_pos),        .V_POS (MODE.v_pos)
    ) u_tim (
        .clk        (clk),
        .rst_n      (rst_n),
        .visible    (visible),
        .frame_start(fstart),
        .hs_level   (hs_lvl),
        .vs_level   (vs_lvl)
    );

    assign uf_eff = o_q.uf & ~fstart;
    assign req    = visible & ~uf_eff;

    generate
        if (BPP == 24) begin : g_bpp24
            vga_unpack24 #(.WORD_W(WORD_W)) u_unp (
                .clk(clk), .rst_n(rst_n), .req(req), .restart(fstart),
                .word(fifo_data), .empty(fifo_empty),
                .pop(fifo_pop), .starve(starve), .pix(pix));
        end else begin : g_bpp16
            vga_unpack16 #(.WORD_W(WORD_W)) u_unp (
                .clk(clk), .rst_n(rst_n), .req(req), .restart(fstart),
                .word(fifo_data), .empty(fifo_empty),
                .pop(fifo_pop), .starve(starve), .pix(pix));
        end
    endgenerate

    always_comb begin
        o_d.hs    = hs_lvl;
        o_d.vs    = vs_lvl;
        o_d.blank = ~visible;
        o_d.uf    = uf_eff | starve;
        o_d.pix   = (req && !starve) ? pix : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q.hs    <= ~MODE.h_pos;
            o_q.vs    <= ~MODE.v_pos;
            o_q.blank <= 1'b1;
            o_q.uf    <= 1'b0;
            o_q.pix   <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign hsync     = o_q.hs;
    assign vsync     = o_q.vs;
    assign blank     = o_q.blank;
    assign underflow = o_q.uf;
    assign red       = o_q.pix.r;
    assign green     = o_q.pix.g;
    assign blue      = o_q.pix.b;

    // R5: never pop an empty FIFO
    a_r5_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);
    // R5: a popped word lands in a visible slot
    a_r5_pop_visible: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !blank);
    // R4: blanked slots carry black
    a_r4_black_blank: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (red == 8'd0 && green == 8'd0 && blue == 8'd0));
    // R9: a starved frame takes no further words
    a_r9_no_pop_starved: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !fstart) |-> !fifo_pop);

endmodule

// File: tb/sim_vga_sequencer.sv
module sim_vga_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wfun(input int j);
        return (32'(j) * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    function automatic logic [23:0] pix24(input int base, input int k);
        logic [31:0] w0, w1, w2;
        int g;
        g  = k / 4;
        w0 = wfun(base + 3 * g);
        w1 = wfun(base + 3 * g + 1);
        w2 = wfun(base + 3 * g + 2);
        case (k % 4)
            0:       return w0[23:0];
            1:       return {w1[15:0], w0[31:24]};
            2:       return {w2[7:0], w1[31:16]};
            default: return w2[31:8];
        endcase
    endfunction

    function automatic logic [23:0] pix16(input int base, input int k);
        logic [31:0] w;
        logic [15:0] h;
        w = wfun(base + k / 2);
        h = (k % 2 == 1) ? w[31:16] : w[15:0];
        return {h[15:11], h[15:13], h[10:5], h[10:9], h[4:0], h[4:2]};
    endfunction

    // u0: small custom mode, 24 bpp (line 16 clocks, frame 8 lines)
    int wcnt0 = 0;
    logic empty0 = 1'b0;
    logic pop0, hs0, vs0, bl0, uf0;
    logic [7:0] r0, g0, b0;
    always @(posedge clk) if (rst_n && pop0) wcnt0 <= wcnt0 + 1;

    vga_sequencer #(.RES(3), .BPP(24),
        .USR_H_ACT(8), .USR_H_FP(2), .USR_H_SYNC(3), .USR_H_BP(3),
        .USR_V_ACT(4), .USR_V_FP(1), .USR_V_SYNC(2), .USR_V_BP(1)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_data(wfun(wcnt0)), .fifo_empty(empty0),
        .fifo_pop(pop0), .hsync(hs0), .vsync(vs0), .blank(bl0),
        .red(r0), .green(g0), .blue(b0), .underflow(uf0));

    // u1: same mode, 16 bpp
    int wcnt1 = 0;
    logic pop1, hs1, vs1, bl1, uf1;
    logic [7:0] r1, g1, b1;
    always @(posedge clk) if (rst_n && pop1) wcnt1 <= wcnt1 + 1;

    vga_sequencer #(.RES(3), .BPP(16),
        .USR_H_ACT(8), .USR_H_FP(2), .USR_H_SYNC(3), .USR_H_BP(3),
        .USR_V_ACT(4), .USR_V_FP(1), .USR_V_SYNC(2), .USR_V_BP(1)) u1 (
        .clk(clk), .rst_n(rst_n), .fifo_data(wfun(wcnt1)), .fifo_empty(1'b0),
        .fifo_pop(pop1), .hsync(hs1), .vsync(vs1), .blank(bl1),
        .red(r1), .green(g1), .blue(b1), .underflow(uf1));

    // u2: 640x480 preset, line timing only
    logic pop2, hs2, vs2, bl2, uf2;
    logic [7:0] r2, g2, b2;
    vga_sequencer #(.RES(0), .BPP(16)) u2 (
        .clk(clk), .rst_n(rst_n), .fifo_data(32'd0), .fifo_empty(1'b1),
        .fifo_pop(pop2), .hsync(hs2), .vsync(vs2), .blank(bl2),
        .red(r2), .green(g2), .blue(b2), .underflow(uf2));

    // Pixel monitors (R4, R7, R8, R9)
    int k0 = 0, base0 = 0, k1 = 0, base1 = 0;
    always @(negedge clk) if (rst_n) begin
        if (!vs0) begin k0 = 0; base0 = wcnt0; end
        if (bl0)      chk({r0, g0, b0} == 24'd0, "R4", {r0, g0, b0}, 0);
        else if (uf0) chk({r0, g0, b0} == 24'd0, "R9", {r0, g0, b0}, 0);
        else begin
            chk({r0, g0, b0} == pix24(base0, k0), "R8", {r0, g0, b0}, pix24(base0, k0));
            k0++;
        end
        if (!vs1) begin k1 = 0; base1 = wcnt1; end
        if (bl1) chk({r1, g1, b1} == 24'd0, "R4", {r1, g1, b1}, 0);
        else begin
            chk({r1, g1, b1} == pix16(base1, k1), "R7", {r1, g1, b1}, pix16(base1, k1));
            k1++;
        end
    end

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(bl0 == 1'b1, "R11 reset blank", bl0, 1);
        chk(hs0 == 1'b1 && vs0 == 1'b1, "R11 reset sync idle", {hs0, vs0}, 2'b11);
        chk({r0, g0, b0} == 24'd0, "R11 reset rgb", {r0, g0, b0}, 0);
        chk(uf0 == 1'b0, "R9 reset flag", uf0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bl0 == 1'b0, "R11 first pixel one clock after release", bl0, 0);
    endtask

    task automatic t_line640();
        int n;
        while (bl2) @(negedge clk);
        n = 0; while (!bl2) begin n++; @(negedge clk); end
        chk(n == 640, "R1 visible run 640", n, 640);
        n = 0; while (hs2) begin n++; @(negedge clk); end
        chk(n == 16, "R2 front porch 16", n, 16);
        n = 0; while (!hs2) begin n++; @(negedge clk); end
        chk(n == 96, "R2 sync low 96", n, 96);
        n = 0; while (hs2) begin n++; @(negedge clk); end
        chk(n == 704, "R1 line rest 704", n, 704);
    endtask

    task automatic t_frame_small();
        int nv, nh, nvs, n;
        nv = 0; nh = 0; nvs = 0;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            if (!bl0) nv++;
            if (!hs0) nh++;
            if (!vs0) nvs++;
        end
        chk(nv == 32, "R4 visible clocks per frame", nv, 32);
        chk(nh == 24, "R2 hsync clocks per frame", nh, 24);
        chk(nvs == 32, "R3 vsync clocks per frame", nvs, 32);
        while (vs0) @(negedge clk);
        n = 0; while (!vs0) begin n++; @(negedge clk); end
        chk(n == 32, "R3 vsync contiguous run", n, 32);
        while (bl0) @(negedge clk);
        while (!bl0) @(negedge clk);
        n = 0; while (hs0) begin n++; @(negedge clk); end
        chk(n == 2, "R2 sync after front porch", n, 2);
    endtask

    task automatic t_pops();
        int w0s, w1s;
        while (vs0) @(negedge clk);
        w0s = wcnt0; w1s = wcnt1;
        repeat (128) @(negedge clk);
        chk(wcnt0 - w0s == 24, "R6 words per frame 24bpp", wcnt0 - w0s, 24);
        chk(wcnt1 - w1s == 16, "R6 words per frame 16bpp", wcnt1 - w1s, 16);
    endtask

    task automatic t_underflow();
        int base;
        while (vs0) @(negedge clk);
        while (bl0) @(negedge clk);
        empty0 = 1'b1;
        @(negedge clk);
        chk(uf0 == 1'b1, "R9 flag rises on starved pixel", uf0, 1);
        chk({r0, g0, b0} == 24'd0, "R9 starved pixel black", {r0, g0, b0}, 0);
        repeat (4) @(negedge clk);
        empty0 = 1'b0;
        repeat (3) @(negedge clk);
        chk(uf0 == 1'b1, "R9 flag sticky after refill", uf0, 1);
        while (vs0) @(negedge clk);
        chk(uf0 == 1'b1, "R9 flag held to frame end", uf0, 1);
        base = wcnt0;
        while (bl0) @(negedge clk);
        chk(uf0 == 1'b0, "R9 flag cleared at frame start", uf0, 0);
        chk({r0, g0, b0} == pix24(base, 0), "R10 group restarts",
            {r0, g0, b0}, pix24(base, 0));
        @(negedge clk);
        chk({r0, g0, b0} == pix24(base, 1), "R10 second pixel of group",
            {r0, g0, b0}, pix24(base, 1));
    endtask

    bit done = 1'b0;
    initial begin
        t_reset();
        t_line640();
        t_frame_small();
        t_pops();
        t_underflow();
        repeat (300) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule